// File: doc/BRIEF.md
# Dual-Mode PWM Edge Generator

This block turns the match events of a free-running, externally owned timer into six pulse-width-modulated outputs. It compares the timer count against seven match values. Slot 0 fixes the repetition period that all channels share: when the count equals it, a new period begins. Each channel can place only its falling edge (single-edge control) or both its edges (double-edge control). Each channel also has its own output enable.

Software writes new match values into holding copies. The copies that drive the comparators change only at a period boundary, and only for slots whose pending-load bit has been set. A running waveform therefore never sees a half-updated pair of edges. The timer and its prescaler live outside the block. The block only evaluates the count in cycles where the count is marked valid.

Top module: `pwm_edge_gen`

## Requirements
- R1: A period starts in a cycle where `cnt_valid_i` is high and `cnt_i` equals the active slot-0 value. All channels share this period.
- R2: A single-edge channel n is driven high at each period start and driven low in a cycle where the count equals the active value of slot n. The output flop updates at the clock edge that samples the count.
- R3: A single-edge channel whose newly active value is 0 is not raised at the period start. A value that is never reached within the period (larger than slot 0) leaves the channel high for the whole period.
- R4: A double-edge channel n (n = 2..6) is raised when the count matches slot n-1 and lowered when it matches slot n. Either order is allowed, giving positive or negative pulses.
- R5: Control word bits 2..6 select double-edge mode (1) or single-edge mode (0) for channels 2..6. Bits 9..14 enable channels 1..6. Channel 1 is always single-edge, whatever bit 1 holds.
- R6: A disabled channel drives its pin low, and its internal waveform keeps running. Re-enabling the channel shows the current level at once.
- R7: A written match value has no effect on the comparators until its load bit (bit m of the load mask for slot m) is set and a later period start occurs. Comparisons in the commit cycle still use the old values.
- R8: Load bits clear themselves at the period start that transfers them. A later write without a new load bit stays pending.
- R9: When a channel's raise condition and its lower condition occur in the same cycle, the channel ends low.
- R10: In cycles with `cnt_valid_i` low, no output changes, whatever `cnt_i` holds.
- R11: Asserting `rst_n` low clears all outputs, match values, load bits and control bits. Reset is applied asynchronously and released through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_valid_i | input | 1 | Count holds a value to be evaluated this cycle |
| cnt_i | input | CNT_W | Timer count |
| mr_wr_i | input | 1 | Write strobe for a match holding copy |
| mr_sel_i | input | SEL_W | Match slot 0..6 to write; 7 is ignored |
| mr_data_i | input | CNT_W | Match value to write |
| ctrl_wr_i | input | 1 | Write strobe for the control word |
| ctrl_data_i | input | 16 | Control word: mode bits 2..6, enable bits 9..14 |
| ler_wr_i | input | 1 | Strobe that sets load bits |
| ler_data_i | input | NUM_CH+1 | Load bits to set, bit m for slot m |
| pwm_o | output | NUM_CH | PWM pins, bit 0 is channel 1 |

## Verification
Two events can land in the same cycle: the period start, which raises single-edge channels and commits pending values, and a channel's lower match. The bench provokes this by committing a slot-3 value equal to the period length. It then expects channel 3 to be high through the following period and low right after the boundary cycle. A second coincidence is the prime step after reset. There, every stale value of zero matches at once alongside the first period start, and all outputs must stay low.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CTRL_W   = 16;
  localparam int MODE_OFS = 1;  // mode bit of channel n sits at bit n
  localparam int EN_OFS   = 9;  // enable bit of channel n sits at bit 8+n

  typedef enum logic {
    EDGE_SINGLE = 1'b0,
    EDGE_DOUBLE = 1'b1
  } edge_mode_e;
endpackage

// File: rtl/pwm_ctrl_reg.sv
module pwm_ctrl_reg
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] data_i,
  output edge_mode_e        mode_o [NUM_CH],
  output logic [NUM_CH-1:0] en_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] ctrl_d;
  logic              unused_ctrl;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i) ctrl_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign unused_ctrl = ^ctrl_q;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_bits
    if (k == 0) begin : g_first
      assign mode_o[k] = EDGE_SINGLE;
    end else begin : g_rest
      assign mode_o[k] = ctrl_q[k + MODE_OFS] ? EDGE_DOUBLE : EDGE_SINGLE;
    end
    assign en_o[k] = ctrl_q[k + EN_OFS];
  end
endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
  parameter int CNT_W  = 32,
  parameter int NUM_MR = 7,
  parameter int SEL_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cnt_valid_i,
  input  logic [CNT_W-1:0]            cnt_i,
  input  logic                        wr_i,
  input  logic [SEL_W-1:0]            sel_i,
  input  logic [CNT_W-1:0]            data_i,
  input  logic                        ler_wr_i,
  input  logic [NUM_MR-1:0]           ler_data_i,
  output logic [NUM_MR-1:0]           match_o,
  output logic                        start_o,
  output logic [NUM_MR-1:0]           nz_next_o,
  output logic [NUM_MR-1:0]           ler_o,
  output logic [NUM_MR-1:0][CNT_W-1:0] active_o
);
  logic [NUM_MR-1:0][CNT_W-1:0] shadow_q, shadow_d;
  logic [NUM_MR-1:0][CNT_W-1:0] active_q, active_d;
  logic [NUM_MR-1:0]            ler_q, ler_d;
  logic                         start;

  for (genvar m = 0; m < NUM_MR; m++) begin : g_cmp
    assign match_o[m] = cnt_valid_i && (cnt_i == active_q[m]);
  end

  assign start = match_o[0];

  always_comb begin
    shadow_d = shadow_q;
    if (wr_i && (int'(sel_i) < NUM_MR)) shadow_d[sel_i] = data_i;
  end

  always_comb begin
    for (int m = 0; m < NUM_MR; m++) begin
      active_d[m]  = (start && ler_q[m]) ? shadow_q[m] : active_q[m];
      nz_next_o[m] = |active_d[m];
    end
  end

  always_comb begin
    ler_d = start ? '0 : ler_q;
    if (ler_wr_i) ler_d = ler_d | ler_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      ler_q    <= '0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
      ler_q    <= ler_d;
    end
  end

  assign start_o  = start;
  assign ler_o    = ler_q;
  assign active_o = active_q;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_valid_i,
  input  logic       start_i,
  input  edge_mode_e mode_i,
  input  logic       set_match_i,
  input  logic       clr_match_i,
  input  logic       nz_next_i,
  output logic       q_o
);
  logic q_q, q_d, set_c;

  always_comb begin
    if (mode_i == EDGE_DOUBLE) set_c = set_match_i;
    else                       set_c = start_i && nz_next_i;
    q_d = q_q;
    if (cnt_valid_i) begin
      if (clr_match_i)  q_d = 1'b0;
      else if (set_c)   q_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
  import pwm_pkg::*;
#(
  parameter  int CNT_W  = 32,
  parameter  int NUM_CH = 6,
  localparam int NUM_MR = NUM_CH + 1,
  localparam int SEL_W  = $clog2(NUM_MR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_valid_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              mr_wr_i,
  input  logic [SEL_W-1:0]  mr_sel_i,
  input  logic [CNT_W-1:0]  mr_data_i,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_data_i,
  input  logic              ler_wr_i,
  input  logic [NUM_MR-1:0] ler_data_i,
  output logic [NUM_CH-1:0] pwm_o
);
  logic [1:0]                   rst_sync_q;
  logic                         rst_sync_n;
  edge_mode_e                   mode [NUM_CH];
  logic [NUM_CH-1:0]            out_en;
  logic [NUM_MR-1:0]            match_vec;
  logic [NUM_MR-1:0]            nz_next;
  logic [NUM_MR-1:0]            ler_q;
  logic [NUM_MR-1:0][CNT_W-1:0] active_vec;
  logic                         cyc_start;
  logic [NUM_CH-1:0]            pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  pwm_ctrl_reg #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_i   (ctrl_wr_i),
    .data_i (ctrl_data_i),
    .mode_o (mode),
    .en_o   (out_en)
  );

  pwm_match_bank #(.CNT_W(CNT_W), .NUM_MR(NUM_MR), .SEL_W(SEL_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cnt_valid_i (cnt_valid_i),
    .cnt_i       (cnt_i),
    .wr_i        (mr_wr_i),
    .sel_i       (mr_sel_i),
    .data_i      (mr_data_i),
    .ler_wr_i    (ler_wr_i),
    .ler_data_i  (ler_data_i),
    .match_o     (match_vec),
    .start_o     (cyc_start),
    .nz_next_o   (nz_next),
    .ler_o       (ler_q),
    .active_o    (active_vec)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    pwm_chan u_chan (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .cnt_valid_i (cnt_valid_i),
      .start_i     (cyc_start),
      .mode_i      (mode[k]),
      .set_match_i (match_vec[k]),
      .clr_match_i (match_vec[k+1]),
      .nz_next_i   (nz_next[k+1]),
      .q_o         (pwm_q[k])
    );
  end

  assign pwm_o = pwm_q & out_en;
endmodule

// File: rtl/pwm_edge_gen_chk.sv
module pwm_edge_gen_chk #(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 6
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cnt_valid_i,
  input logic                          ler_wr_i,
  input logic                          cyc_start,
  input logic [NUM_CH:0]               match_vec,
  input logic [NUM_CH:0]               ler_q,
  input logic [NUM_CH:0][CNT_W-1:0]    active_vec,
  input logic [NUM_CH-1:0]             pwm_q
);
  p_ler_self_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !ler_wr_i) |=> (ler_q == '0));

  p_commit_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> $stable(active_vec));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_valid_i |=> $stable(pwm_q));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_a
    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      match_vec[k+1] |=> !pwm_q[k]);

    p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_q[k]) |-> $past(cyc_start || match_vec[k]));
  end
endmodule

bind pwm_edge_gen pwm_edge_gen_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cnt_valid_i (cnt_valid_i),
  .ler_wr_i    (ler_wr_i),
  .cyc_start   (cyc_start),
  .match_vec   (match_vec),
  .ler_q       (ler_q),
  .active_vec  (active_vec),
  .pwm_q       (pwm_q)
);

// File: tb/pwm_edge_gen_bench.sv
module pwm_edge_gen_bench;
  localparam int CW = 32;
  localparam int NC = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cnt_valid_i;
  logic [CW-1:0] cnt_i;
  logic          mr_wr_i;
  logic [2:0]    mr_sel_i;
  logic [CW-1:0] mr_data_i;
  logic          ctrl_wr_i;
  logic [15:0]   ctrl_data_i;
  logic          ler_wr_i;
  logic [6:0]    ler_data_i;
  logic [NC-1:0] pwm_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  pwm_edge_gen #(.CNT_W(CW), .NUM_CH(NC)) u_pwm_edge_gen (
    .clk(clk), .rst_n(rst_n), .cnt_valid_i(cnt_valid_i), .cnt_i(cnt_i),
    .mr_wr_i(mr_wr_i), .mr_sel_i(mr_sel_i), .mr_data_i(mr_data_i),
    .ctrl_wr_i(ctrl_wr_i), .ctrl_data_i(ctrl_data_i),
    .ler_wr_i(ler_wr_i), .ler_data_i(ler_data_i), .pwm_o(pwm_o)
  );

  // {valid, count[7:0], expected ch6..ch1}
  localparam int NV = 21;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 8'd0, 6'b000000}, // prime: first period start (R1, R9)
    {1'b1, 8'd1, 6'b000000},
    {1'b1, 8'd2, 6'b001000}, // ch4 double raised by slot 3 (R4)
    {1'b1, 8'd3, 6'b001000},
    {1'b1, 8'd4, 6'b001000},
    {1'b1, 8'd5, 6'b001000},
    {1'b1, 8'd6, 6'b001000},
    {1'b1, 8'd7, 6'b010000}, // ch4 lowered, ch5 raised (R4)
    {1'b1, 8'd8, 6'b010000},
    {1'b1, 8'd9, 6'b110111}, // period start raises single-edge (R1, R2)
    {1'b1, 8'd0, 6'b110111},
    {1'b1, 8'd1, 6'b110111},
    {1'b1, 8'd2, 6'b111011},
    {1'b1, 8'd3, 6'b111010}, // ch1 lowered (R2)
    {1'b1, 8'd4, 6'b101010}, // negative pulse ch5 (R4)
    {1'b1, 8'd5, 6'b101010},
    {1'b1, 8'd6, 6'b101000},
    {1'b1, 8'd7, 6'b110000},
    {1'b0, 8'd2, 6'b110000}, // invalid count ignored (R10)
    {1'b1, 8'd8, 6'b110000},
    {1'b1, 8'd9, 6'b110111}  // ch6 above period stays high (R3), modes (R5)
  };

  task automatic chk(input string req, input logic [NC-1:0] act, input logic [NC-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input int c);
    cnt_valid_i = v;
    cnt_i       = CW'(c);
    @(negedge clk);
    cnt_valid_i = 1'b0;
  endtask

  task automatic run(input int a, input int b);
    for (int c = a; c <= b; c++) step(1'b1, c);
  endtask

  task automatic wr_mr(input int sel, input int val);
    mr_wr_i = 1'b1; mr_sel_i = 3'(sel); mr_data_i = CW'(val);
    @(negedge clk);
    mr_wr_i = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [15:0] val);
    ctrl_wr_i = 1'b1; ctrl_data_i = val;
    @(negedge clk);
    ctrl_wr_i = 1'b0;
  endtask

  task automatic wr_ler(input logic [6:0] val);
    ler_wr_i = 1'b1; ler_data_i = val;
    @(negedge clk);
    ler_wr_i = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired, all of R1..R11 unfinished actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_valid_i = 1'b0; cnt_i = '0;
    mr_wr_i = 1'b0; mr_sel_i = '0; mr_data_i = '0;
    ctrl_wr_i = 1'b0; ctrl_data_i = '0; ler_wr_i = 1'b0; ler_data_i = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", pwm_o, 6'b000000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // ch4, ch5 double-edge; all enabled (R5)
    wr_ctrl(16'h7E30);
    wr_mr(0, 9); wr_mr(1, 3); wr_mr(2, 6); wr_mr(3, 2);
    wr_mr(4, 7); wr_mr(5, 4); wr_mr(6, 12);
    wr_ler(7'h7F);
    chk("R7 no output before commit", pwm_o, 6'b000000);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][14], int'(VEC[i][13:6]));
      chk($sformatf("R1/R2/R4/R5/R10 vector %0d", i), pwm_o, VEC[i][5:0]);
    end

    // R7: write without load bit, then with load bit
    wr_mr(1, 5);
    run(0, 2);
    chk("R7 old slot1 still high", {5'b0, pwm_o[0]}, 6'd1);
    step(1'b1, 3);
    chk("R7 old slot1 lowers at 3", {5'b0, pwm_o[0]}, 6'd0);
    wr_ler(7'h02);
    run(4, 9);
    run(0, 4);
    chk("R7 new slot1 keeps high at 4", {5'b0, pwm_o[0]}, 6'd1);
    step(1'b1, 5);
    chk("R7 new slot1 lowers at 5", {5'b0, pwm_o[0]}, 6'd0);

    // R8: load bit consumed, later write stays pending
    wr_mr(1, 8);
    run(6, 9);
    run(0, 5);
    chk("R8 pending value not applied", {5'b0, pwm_o[0]}, 6'd0);

    // R3: zero value keeps single-edge channel low; over-period stays high
    wr_mr(2, 0);
    wr_ler(7'h04);
    run(6, 9);
    chk("R3 zero value not raised", {5'b0, pwm_o[1]}, 6'd0);
    step(1'b1, 0);
    chk("R3 zero value low at 0", {5'b0, pwm_o[1]}, 6'd0);
    chk("R3 over-period high", {5'b0, pwm_o[5]}, 6'd1);

    // R9: lower match coincides with period start
    wr_mr(3, 9);
    wr_ler(7'h08);
    run(1, 9);
    run(0, 8);
    chk("R9 ch3 high before boundary", {5'b0, pwm_o[2]}, 6'd1);
    step(1'b1, 9);
    chk("R9 clear wins at boundary", {5'b0, pwm_o[2]}, 6'd0);

    // R5: bit 1 does not change channel 1
    wr_ctrl(16'h7E32);
    run(0, 9);
    chk("R5 ch1 single-edge raised", {5'b0, pwm_o[0]}, 6'd1);

    // R6: disable ch6, waveform keeps running
    wr_ctrl(16'h3E32);
    chk("R6 disabled pin low", {5'b0, pwm_o[5]}, 6'd0);
    wr_ctrl(16'h7E32);
    chk("R6 re-enabled shows level", {5'b0, pwm_o[5]}, 6'd1);

    // R10: invalid count matching slot 1 is ignored
    step(1'b0, 5);
    chk("R10 invalid count ignored", {5'b0, pwm_o[0]}, 6'd1);

    // R11: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset clears outputs", pwm_o, 6'b000000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    summary();
    $finish;
  end
endmodule